// File: doc/BRIEF.md
# Single-Wire Pulse-Width Register Access Slave

This block is the target side of a one-wire serial link. The link uses one open-drain data line with a pull-up. A host reaches a 256-location register space over that line. Every symbol on the line begins with a falling edge, and the length of the low pulse that follows carries the bit value. A frame has four parts in order:

- a long low pulse that opens the frame;
- a three-bit operation code;
- an eight-bit location;
- for stores only, a guard bit and an eight-bit value.

Locations below 128 are forwarded to a register port. That port writes in one cycle and returns read data on the cycle after the read strobe. Locations from 128 upward are forwarded to a memory port with the top address bit removed. That port uses a request/acknowledge handshake with an unbounded response time.

For a load, the host lets go of the line after the location. The block then pulls the line low as a wait state until the data has arrived. It ends that low phase as the first, throw-away symbol of its reply, and then sends the eight data bits with the same pulse-width coding. The block only ever pulls the line low or releases it. The line is resynchronised and deglitched before any edge is used. A frame that stalls too long between falling edges is dropped.

Top module: `sw_pwm_slave`

## Requirements
- R1: While reset is held, and right after it, the line is released and no register or memory strobe is active.
- R2: A frame opens only on a low pulse of at least START_MIN cycles (default 40). A shorter low pulse while idle opens nothing.
- R3: A low pulse that follows less than IDLE_MIN cycles (default 60) of high line cannot open a frame, whatever its length.
- R4: A low pulse shorter than BIT_THRESH cycles (default 12) is a 1, and a longer one is a 0. The location and the value are sent most significant bit first.
- R5: Code 000 is a store and code 001 is a load. Any other code ends the frame with no access and no line activity.
- R6: A store to a location below 128 gives exactly one single-cycle register write strobe, carrying the low seven location bits and the value.
- R7: An access at location 128 or above raises a memory request with address = location − 128. Request, address and direction stay unchanged until acknowledge.
- R8: The guard bit of a store must be 0. A 1 drops the store, so no write reaches either port.
- R9: After the last location bit of a load, the block pulls the line low within 20 cycles. It holds the line low until the data is in hand.
- R10: The reply is a throw-away 0 symbol followed by eight data bits, most significant first. Each symbol lasts TX_BIT_LEN (40) cycles. A 1 is low for TX_ONE_LOW (5) cycles and a 0 is low for TX_ZERO_LOW (20) cycles.
- R11: Inside a frame, a falling edge that arrives exactly TIMEOUT cycles after the previous one keeps the frame alive. If TIMEOUT cycles pass with no edge, the frame is dropped.
- R12: The line is never pulled while the host is sending a frame. It is pulled only during the load wait and the reply.
- R13: A load below location 128 gives exactly one single-cycle register read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Sensed level of the shared line |
| line_oe | output | 1 | Pull the line low when 1 |
| reg_we | output | 1 | Register write strobe |
| reg_re | output | 1 | Register read strobe |
| reg_addr | output | 7 | Register location |
| reg_wdata | output | 8 | Register write value |
| reg_rdata | input | 8 | Register read value, valid the cycle after reg_re |
| ext_req | output | 1 | Memory request, held until acknowledge |
| ext_we | output | 1 | Memory direction, 1 = store |
| ext_addr | output | 7 | Memory address (location − 128) |
| ext_wdata | output | 8 | Memory store value |
| ext_ack | input | 1 | Memory acknowledge, one cycle |
| ext_rdata | input | 8 | Memory load value, valid with ext_ack |

## Verification
The frame timeout and the arrival of the next falling edge can land in the same cycle. The edge must win. The bench provokes this by stretching one location bit so that falling edges are exactly TIMEOUT cycles apart, and it expects the store to complete. It then repeats the frame with one cycle more, and there it expects no write at either port. A second coincidence is between the host releasing the line and the block starting its wait-state pull. The bench judges that by showing the line never goes low for the block during host phases and does go low within the R9 window after the location.

// File: rtl/sw_pkg.sv
package sw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_FILL, ST_DATA, ST_WR_EXT, ST_RD_WAIT, ST_TX
  } sw_state_e;

  localparam logic [2:0] OP_STORE = 3'b000;
  localparam logic [2:0] OP_LOAD  = 3'b001;
endpackage

// File: rtl/sw_line_rx.sv
module sw_line_rx #(
  parameter int FILT_LEN = 3,
  parameter int CNT_W    = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_in,
  output logic             fall,
  output logic             rise,
  output logic [CNT_W-1:0] low_len,
  output logic [CNT_W-1:0] high_len
);
  localparam int FW = $clog2(FILT_LEN + 1);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [1:0]    sync_q;
  logic [FW-1:0] fcnt;
  logic          filt, filt_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 2'b11;
    else     sync_q <= {sync_q[0], line_in};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fcnt   <= '0;
      filt   <= 1'b1;
      filt_q <= 1'b1;
    end else begin
      filt_q <= filt;
      if (sync_q[1] != filt) begin
        if (fcnt == FW'(FILT_LEN - 1)) begin
          filt <= sync_q[1];
          fcnt <= '0;
        end else begin
          fcnt <= fcnt + 1'b1;
        end
      end else begin
        fcnt <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      low_len  <= '0;
      high_len <= '0;
    end else if (filt) begin
      low_len <= '0;
      if (high_len != CMAX) high_len <= high_len + 1'b1;
    end else begin
      high_len <= '0;
      if (low_len != CMAX) low_len <= low_len + 1'b1;
    end
  end

  assign fall = filt_q & ~filt;
  assign rise = ~filt_q & filt;

  assert_pulse_len_R4: assert property (@(posedge clk) disable iff (rst)
    rise |-> (low_len != '0));
endmodule

// File: rtl/sw_pwm_tx.sv
module sw_pwm_tx #(
  parameter int DATA_W    = 8,
  parameter int ONE_LOW   = 5,
  parameter int ZERO_LOW  = 20,
  parameter int BIT_LEN   = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [DATA_W-1:0] data,
  output logic              oe,
  output logic              busy,
  output logic              done
);
  localparam int IW = $clog2(DATA_W + 1);
  localparam int CW = $clog2(BIT_LEN + 1);

  logic            active;
  logic [IW-1:0]   idx;
  logic [CW-1:0]   cyc;
  logic [DATA_W:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      idx    <= '0;
      cyc    <= '0;
      sh     <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go && !active) begin
        active <= 1'b1;
        idx    <= '0;
        cyc    <= '0;
        sh     <= {1'b0, data};
      end else if (active) begin
        if (cyc == CW'(BIT_LEN - 1)) begin
          cyc <= '0;
          sh  <= {sh[DATA_W-1:0], 1'b0};
          if (idx == IW'(DATA_W)) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end else begin
          cyc <= cyc + 1'b1;
        end
      end
    end
  end

  assign oe   = active && (cyc < (sh[DATA_W] ? CW'(ONE_LOW) : CW'(ZERO_LOW)));
  assign busy = active;

  assert_reply_starts_low_R10: assert property (@(posedge clk) disable iff (rst)
    (go && !active) |=> (active && oe));
endmodule

// File: rtl/sw_pwm_slave.sv
module sw_pwm_slave
  import sw_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 8,
  parameter int FILT_LEN    = 3,
  parameter int BIT_THRESH  = 12,
  parameter int START_MIN   = 40,
  parameter int IDLE_MIN    = 60,
  parameter int TIMEOUT     = 300,
  parameter int TX_ONE_LOW  = 5,
  parameter int TX_ZERO_LOW = 20,
  parameter int TX_BIT_LEN  = 40
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                line_in,
  output logic                line_oe,
  output logic                reg_we,
  output logic                reg_re,
  output logic [ADDR_W-2:0]   reg_addr,
  output logic [DATA_W-1:0]   reg_wdata,
  input  logic [DATA_W-1:0]   reg_rdata,
  output logic                ext_req,
  output logic                ext_we,
  output logic [ADDR_W-2:0]   ext_addr,
  output logic [DATA_W-1:0]   ext_wdata,
  input  logic                ext_ack,
  input  logic [DATA_W-1:0]   ext_rdata
);
  localparam int LOC_W = ADDR_W - 1;
  localparam int SH_W  = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
  localparam int BCW   = $clog2(SH_W + 1);
  localparam int CNT_W = $clog2(TIMEOUT + START_MIN + IDLE_MIN + 2);
  localparam logic [CNT_W-1:0] CMAX = '1;

  sw_state_e         state;
  logic              fall, rise, bit_val, armed, is_rd, wait_low, in_frame, stalled;
  logic [CNT_W-1:0]  low_len, high_len, tmo_cnt;
  logic [BCW-1:0]    bit_cnt;
  logic [SH_W-1:0]   sh, nxt;
  logic [ADDR_W-1:0] loc_q;
  logic [DATA_W-1:0] tx_data;
  logic              tx_go, tx_oe, tx_busy, tx_done;

  sw_line_rx #(.FILT_LEN(FILT_LEN), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst(rst), .line_in(line_in),
    .fall(fall), .rise(rise), .low_len(low_len), .high_len(high_len)
  );

  sw_pwm_tx #(.DATA_W(DATA_W), .ONE_LOW(TX_ONE_LOW), .ZERO_LOW(TX_ZERO_LOW),
              .BIT_LEN(TX_BIT_LEN)) u_tx (
    .clk(clk), .rst(rst), .go(tx_go), .data(tx_data),
    .oe(tx_oe), .busy(tx_busy), .done(tx_done)
  );

  assign bit_val  = (low_len < CNT_W'(BIT_THRESH));
  assign nxt      = {sh[SH_W-2:0], bit_val};
  assign in_frame = (state == ST_CMD) || (state == ST_ADDR) ||
                    (state == ST_FILL) || (state == ST_DATA);
  assign stalled  = in_frame && !fall && (tmo_cnt == CNT_W'(TIMEOUT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tmo_cnt <= '0;
    end else if (fall || state == ST_IDLE) begin
      tmo_cnt <= '0;
    end else if (tmo_cnt != CMAX) begin
      tmo_cnt <= tmo_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      armed     <= 1'b0;
      is_rd     <= 1'b0;
      wait_low  <= 1'b0;
      bit_cnt   <= '0;
      sh        <= '0;
      loc_q     <= '0;
      tx_data   <= '0;
      tx_go     <= 1'b0;
      reg_we    <= 1'b0;
      reg_re    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      ext_req   <= 1'b0;
      ext_we    <= 1'b0;
      ext_addr  <= '0;
      ext_wdata <= '0;
      line_oe   <= 1'b0;
    end else begin
      reg_we  <= 1'b0;
      tx_go   <= 1'b0;
      line_oe <= wait_low | tx_oe;
      if (stalled) begin
        state <= ST_IDLE;
        armed <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: begin
            if (fall) armed <= (high_len >= CNT_W'(IDLE_MIN));
            if (rise) begin
              armed <= 1'b0;
              if (armed && low_len >= CNT_W'(START_MIN)) begin
                state   <= ST_CMD;
                bit_cnt <= '0;
              end
            end
          end
          ST_CMD: if (rise) begin
            sh <= nxt;
            if (bit_cnt == BCW'(2)) begin
              bit_cnt <= '0;
              if (nxt[2:0] == OP_STORE) begin
                state <= ST_ADDR;
                is_rd <= 1'b0;
              end else if (nxt[2:0] == OP_LOAD) begin
                state <= ST_ADDR;
                is_rd <= 1'b1;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          ST_ADDR: if (rise) begin
            sh <= nxt;
            if (bit_cnt == BCW'(ADDR_W - 1)) begin
              bit_cnt <= '0;
              loc_q   <= nxt[ADDR_W-1:0];
              if (is_rd) begin
                state    <= ST_RD_WAIT;
                wait_low <= 1'b1;
                if (nxt[ADDR_W-1]) begin
                  ext_req  <= 1'b1;
                  ext_we   <= 1'b0;
                  ext_addr <= nxt[LOC_W-1:0];
                end else begin
                  reg_re   <= 1'b1;
                  reg_addr <= nxt[LOC_W-1:0];
                end
              end else begin
                state <= ST_FILL;
              end
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          ST_FILL: if (rise) begin
            state <= bit_val ? ST_IDLE : ST_DATA;
          end
          ST_DATA: if (rise) begin
            sh <= nxt;
            if (bit_cnt == BCW'(DATA_W - 1)) begin
              bit_cnt <= '0;
              if (loc_q[ADDR_W-1]) begin
                ext_req   <= 1'b1;
                ext_we    <= 1'b1;
                ext_addr  <= loc_q[LOC_W-1:0];
                ext_wdata <= nxt[DATA_W-1:0];
                state     <= ST_WR_EXT;
              end else begin
                reg_we    <= 1'b1;
                reg_addr  <= loc_q[LOC_W-1:0];
                reg_wdata <= nxt[DATA_W-1:0];
                state     <= ST_IDLE;
              end
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          ST_WR_EXT: if (ext_ack) begin
            ext_req <= 1'b0;
            ext_we  <= 1'b0;
            state   <= ST_IDLE;
          end
          ST_RD_WAIT: begin
            if (loc_q[ADDR_W-1]) begin
              if (ext_ack) begin
                ext_req <= 1'b0;
                tx_data <= ext_rdata;
                tx_go   <= 1'b1;
                state   <= ST_TX;
              end
            end else if (reg_re) begin
              reg_re <= 1'b0;
            end else begin
              tx_data <= reg_rdata;
              tx_go   <= 1'b1;
              state   <= ST_TX;
            end
          end
          ST_TX: begin
            if (tx_busy) wait_low <= 1'b0;
            if (tx_done) begin
              state <= ST_IDLE;
              armed <= 1'b0;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assert_quiet_in_frame_R12: assert property (@(posedge clk) disable iff (rst)
    in_frame |-> !line_oe);
  assert_wait_pull_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RD_WAIT) |=> line_oe);
  assert_req_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (ext_req && !ext_ack) |=> (ext_req && $stable(ext_addr) && $stable(ext_we)));
  assert_write_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);
  assert_read_pulse_R13: assert property (@(posedge clk) disable iff (rst)
    reg_re |=> !reg_re);
  assert_one_port_R7: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && reg_re) && !(ext_req && (reg_we || reg_re)));
endmodule

// File: tb/sim_sw_pwm_slave.sv
module sim_sw_pwm_slave;
  localparam int TMO = 300;
  localparam int PER = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic       m_oe = 1'b0;
  logic       line_oe, line;
  logic       reg_we, reg_re, ext_req, ext_we;
  logic [6:0] reg_addr, ext_addr;
  logic [7:0] reg_wdata, ext_wdata;
  logic [7:0] reg_rdata = 8'h00;
  logic [7:0] ext_rdata = 8'h00;
  logic       ext_ack = 1'b0;

  assign line = ~(m_oe | line_oe);

  sw_pwm_slave #(.TIMEOUT(TMO)) u0 (
    .clk(clk), .rst(rst), .line_in(line), .line_oe(line_oe),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ext_req(ext_req), .ext_we(ext_we), .ext_addr(ext_addr),
    .ext_wdata(ext_wdata), .ext_ack(ext_ack), .ext_rdata(ext_rdata)
  );

  int total = 0, bad = 0, act_cnt = 0, re_cnt = 0, cyc = 0;
  int ext_lat = 2, ext_wait = 0;
  logic quiet = 1'b1, drove_seen = 1'b0;
  logic [15:0] expq[$];
  logic [7:0] regs [128];
  logic [7:0] emem [128];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pop_chk(input logic [15:0] got);
    logic [15:0] e;
    if (expq.size() == 0) begin
      chk(1'b0, got[15] ? "R7 unexpected memory store" : "R6 unexpected register write",
          int'(got), 0);
    end else begin
      e = expq.pop_front();
      chk(e == got, got[15] ? "R7 memory store content" : "R6 register write content",
          int'(got), int'(e));
    end
  endtask

  // per-clock reference: expected writes, line ownership, port models
  always @(negedge clk) begin
    if (!rst) begin
      if (quiet && line_oe && !drove_seen) begin
        drove_seen = 1'b1;
        total++; bad++;
        $display("FAIL R12 line pulled during host phase actual=1 expected=0");
      end
      if (reg_re) begin
        act_cnt++; re_cnt++;
        reg_rdata = regs[reg_addr];
      end
      if (reg_we) begin
        act_cnt++;
        pop_chk({1'b0, reg_addr, reg_wdata});
        regs[reg_addr] = reg_wdata;
      end
      if (ext_req && !ext_ack) begin
        if (ext_wait >= ext_lat) begin
          ext_ack  = 1'b1;
          ext_wait = 0;
          act_cnt++;
          if (ext_we) begin
            pop_chk({1'b1, ext_addr, ext_wdata});
            emem[ext_addr] = ext_wdata;
          end else begin
            ext_rdata = emem[ext_addr];
          end
        end else begin
          ext_wait++;
        end
      end else begin
        ext_ack = 1'b0;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic drv(input bit low, input int n);
    @(negedge clk);
    m_oe = low;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic send_bit(input bit b, input int per);
    drv(1'b1, b ? 6 : 20);
    drv(1'b0, per - (b ? 6 : 20));
  endtask

  task automatic wr_frame(input int st_len, input logic [2:0] op, input logic [7:0] a,
                          input bit fill, input logic [7:0] d, input int slow_k,
                          input int slow_per, input int idle_after);
    logic [19:0] seq;
    seq = {op, a, fill, d};
    drv(1'b1, st_len);
    drv(1'b0, 20);
    for (int k = 0; k < 20; k++) send_bit(seq[19-k], (k == slow_k) ? slow_per : PER);
    drv(1'b0, idle_after);
  endtask

  task automatic rd_frame(input logic [7:0] a, input int lat, output logic [7:0] d);
    logic [8:0] got;
    int w, re0;
    got = '0;
    ext_lat = lat;
    re0 = re_cnt;
    drv(1'b1, 50);
    drv(1'b0, 20);
    send_bit(1'b0, PER); send_bit(1'b0, PER); send_bit(1'b1, PER);
    for (int k = 0; k < 7; k++) send_bit(a[7-k], PER);
    drv(1'b1, a[0] ? 6 : 20);
    @(negedge clk);
    m_oe  = 1'b0;
    quiet = 1'b0;
    @(negedge clk);
    w = 1;
    while (line && w < 40) begin @(negedge clk); w++; end
    chk(w < 20, "R9 wait pull after location", w, 20);
    for (int i = 0; i < 9; i++) begin
      int len;
      len = 0;
      if (i > 0) begin
        int g;
        g = 0;
        while (line && g < 200) begin @(negedge clk); g++; end
      end
      while (!line && len < 5000) begin @(negedge clk); len++; end
      got = {got[7:0], (len < 12)};
      if (i > 0) chk(len == 5 || len == 20, "R10 reply symbol low time", len, 5);
    end
    d = got[7:0];
    quiet = 1'b1;
    if (!a[7]) chk(re_cnt - re0 == 1, "R13 single register read strobe", re_cnt - re0, 1);
    drv(1'b0, 80);
  endtask

  initial begin
    logic [7:0] rd;
    int a0;
    for (int i = 0; i < 128; i++) begin
      regs[i] = 8'h00;
      emem[i] = 8'(i) ^ 8'h55;
    end
    repeat (5) @(negedge clk);
    chk(line_oe == 0 && reg_we == 0 && reg_re == 0 && ext_req == 0,
        "R1 reset state", {line_oe, reg_we, reg_re, ext_req}, 0);
    rst = 1'b0;
    drv(1'b0, 100);
    chk(line_oe == 0 && ext_req == 0, "R1 after reset", {line_oe, ext_req}, 0);

    // R4 R6: register stores
    expq.push_back({1'b0, 7'h05, 8'hA6});
    wr_frame(50, 3'b000, 8'h05, 1'b0, 8'hA6, -1, 0, 80);
    expq.push_back({1'b0, 7'h7F, 8'h01});
    wr_frame(50, 3'b000, 8'h7F, 1'b0, 8'h01, -1, 0, 80);
    chk(expq.size() == 0, "R6 register stores done", expq.size(), 0);

    // R9 R10 R13: register loads
    rd_frame(8'h05, 0, rd);  chk(rd == 8'hA6, "R10 load 0x05", rd, 8'hA6);
    rd_frame(8'h7F, 0, rd);  chk(rd == 8'h01, "R10 load 0x7F", rd, 8'h01);

    // R7: memory stores and loads at offset 128
    ext_lat = 3;
    expq.push_back({1'b1, 7'h00, 8'h5C});
    wr_frame(50, 3'b000, 8'h80, 1'b0, 8'h5C, -1, 0, 80);
    ext_lat = 12;
    expq.push_back({1'b1, 7'd72, 8'h3E});
    wr_frame(50, 3'b000, 8'hC8, 1'b0, 8'h3E, -1, 0, 80);
    chk(expq.size() == 0, "R7 memory stores done", expq.size(), 0);
    rd_frame(8'hC8, 20, rd); chk(rd == 8'h3E, "R7 load 0xC8 slow", rd, 8'h3E);
    rd_frame(8'h80, 0, rd);  chk(rd == 8'h5C, "R7 load 0x80 fast", rd, 8'h5C);
    rd_frame(8'hFF, 5, rd);  chk(rd == 8'h2A, "R7 load 0xFF untouched", rd, 8'h2A);

    // R5: illegal codes
    a0 = act_cnt;
    wr_frame(50, 3'b011, 8'h05, 1'b0, 8'hFF, -1, 0, 80);
    wr_frame(50, 3'b100, 8'h05, 1'b0, 8'hFF, -1, 0, 80);
    chk(act_cnt == a0, "R5 illegal code has no access", act_cnt - a0, 0);

    // R2: short opening pulse
    wr_frame(30, 3'b000, 8'h05, 1'b0, 8'h11, -1, 0, 80);
    chk(act_cnt == a0, "R2 short opening ignored", act_cnt - a0, 0);

    // R3: too little idle before opening
    expq.push_back({1'b0, 7'h20, 8'h3C});
    wr_frame(50, 3'b000, 8'h20, 1'b0, 8'h3C, -1, 0, 5);
    wr_frame(50, 3'b000, 8'h20, 1'b0, 8'hC3, -1, 0, 80);
    rd_frame(8'h20, 0, rd);  chk(rd == 8'h3C, "R3 early opening ignored", rd, 8'h3C);

    // R8: guard bit set
    wr_frame(50, 3'b000, 8'h05, 1'b1, 8'h99, -1, 0, 80);
    rd_frame(8'h05, 0, rd);  chk(rd == 8'hA6, "R8 guard 1 drops store", rd, 8'hA6);

    // R11: timeout edge coincidence
    expq.push_back({1'b0, 7'h10, 8'h77});
    wr_frame(50, 3'b000, 8'h10, 1'b0, 8'h77, 5, TMO, 80);
    chk(expq.size() == 0, "R11 edge at exact limit keeps frame", expq.size(), 0);
    a0 = act_cnt;
    wr_frame(50, 3'b000, 8'h11, 1'b0, 8'h11, 5, TMO + 1, 80);
    chk(act_cnt == a0, "R11 one cycle late drops frame", act_cnt - a0, 0);
    rd_frame(8'h11, 0, rd);  chk(rd == 8'h00, "R11 dropped store absent", rd, 8'h00);

    chk(expq.size() == 0, "R6 no outstanding writes", expq.size(), 0);
    chk(!drove_seen, "R12 line free in host phases", drove_seen, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule